// File: doc/BRIEF.md
# Tone Correlation Response Analyzer

This block measures how strongly one chosen frequency is present in a stream of digitized response samples, without a Fourier transform. It holds its own reference tone generator: a phase accumulator advanced by a tuning word, whose phase is shaped into a sinusoid-like value. On every clock while a measurement runs, the incoming ADC sample is multiplied by the current reference value. The scaled product is added into a wide signed accumulator. The final total, divided by the number of samples taken, is a DC figure that tracks the response power at the reference frequency.

A measurement ends only when the reference phase has wrapped a programmed number of times. The sum therefore always spans whole reference periods, which suppresses the ripple that slow mixing terms leave on the running total. Longer runs suppress it further. A test controller typically runs the block twice: once tuned to the fundamental and once to the third-order product. It then takes the ratio of the two results off-block.

The control is a three-state machine. ST_IDLE waits for start (transition idle_to_run). ST_RUN accumulates. It restarts itself on a new start (run_restart) and moves to ST_DONE on the wrap that completes the target (run_to_done). ST_DONE lasts one cycle and then returns to ST_IDLE (done_to_idle), or to ST_RUN if start is present (done_to_run).

Top module: `tone_corr_ora`

## Requirements
- R1: While reset is asserted and after it is released with no start, done is 0 and result is 0.
- R2: A start pulse clears the accumulator, the reference phase and the period count. In the cycle after start is sampled, result reads 0 and done is 0.
- R3: The reference value for phase p (PW bits) is computed as follows. Take u = p[PW-2:PW-N] (K = N-1 bits) and mag = min((u*(2^K-u)) >> (K-2), 2^K-1). The reference is -mag when p[PW-1] is 1 and +mag otherwise. The first accumulated sample after start uses phase 0, and the phase then advances by the tuning word on every accumulated sample.
- R4: Each accumulated term is the signed product of sample and reference, arithmetically shifted right by N-1 and kept as N signed bits. It is sign-extended to N+M bits before it is added.
- R5: Let L be the smallest k for which k*tune_word reaches max(target,1)*2^PW. Exactly L samples are accumulated: the ones sampled on the L clock edges after the start edge. done is high for exactly one cycle, the one after the L-th of those edges, and result is final in that cycle.
- R6: After done, result keeps its value until the next start.
- R7: The tuning word and the period target are captured when start is sampled. Changing them during a run does not change the result or the run length.
- R8: A start during a run abandons it without a done pulse and begins a fresh measurement.
- R9: The N+M-bit accumulator does not overflow for runs of fewer than 2^M samples.
- R10: A period target of 0 ends the run on the first wrap, exactly as a target of 1 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a measurement |
| tune_word | input | PW (16) | Reference phase increment per sample |
| period_target | input | CW (8) | Number of reference periods to accumulate |
| adc_sample | input | N (8) | Signed response sample |
| result | output | N+M (17) | Signed accumulated correlation |
| done | output | 1 | One-cycle flag that the measurement has ended |

## Verification
The start edge is edge 0. Sample k is accumulated on edge k. done and the final result are due half a cycle after edge L, and the cleared result is due half a cycle after edge 0. The bench computes L and the expected sum from the reference formula before driving a run and queues them. A monitor sampling on the falling clock edge checks both the total and an edge count kept since start whenever done appears, and reports a done with no queued entry as a failure. Hold, restart and mid-run parameter changes are then checked a fixed number of falling edges later.

// File: rtl/ora_pkg.sv
package ora_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ora_state_e;
endpackage

// File: rtl/ora_ref_tone.sv
module ora_ref_tone #(
    parameter int PW = 16,
    parameter int N  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [PW-1:0]       tw_in,
    output logic signed [N-1:0] ref_o,
    output logic                wrap_o
);
    localparam int K  = N - 1;
    localparam int W2 = 2 * K + 2;
    localparam logic [W2-1:0] MAG_MAX = W2'((1 << K) - 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] tw_q;
    logic [PW:0]   nxt;
    logic [K-1:0]  u;
    logic [K:0]    cu;
    logic [W2-1:0] shp;
    logic [W2-1:0] shp_sh;
    logic [K-1:0]  mag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            tw_q  <= '0;
        end else if (clr) begin
            phase <= '0;
            tw_q  <= tw_in;
        end else if (en) begin
            phase <= nxt[PW-1:0];
        end
    end

    always_comb begin
        nxt    = {1'b0, phase} + {1'b0, tw_q};
        wrap_o = en & nxt[PW];
        u      = phase[PW-2 -: K];
        cu     = (K+1)'(1 << K) - {1'b0, u};
        shp    = {{(K+2){1'b0}}, u} * {{(K+1){1'b0}}, cu};
        shp_sh = shp >> (K - 2);
        if (shp_sh > MAG_MAX) begin
            mag = MAG_MAX[K-1:0];
        end else begin
            mag = shp_sh[K-1:0];
        end
        if (phase[PW-1]) begin
            ref_o = -$signed({1'b0, mag});
        end else begin
            ref_o = $signed({1'b0, mag});
        end
    end
endmodule

// File: rtl/ora_mac.sv
module ora_mac #(
    parameter int N  = 8,
    parameter int AW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [N-1:0]  sample,
    input  logic signed [N-1:0]  ref_v,
    output logic signed [AW-1:0] acc_o,
    output logic signed [AW-1:0] prod_ext_o
);
    localparam int PWID = 2 * N;

    logic signed [PWID-1:0] full;
    logic signed [PWID-1:0] scaled;
    logic signed [N-1:0]    prod;

    always_comb begin
        full       = $signed({{N{sample[N-1]}}, sample}) * $signed({{N{ref_v[N-1]}}, ref_v});
        scaled     = full >>> (N - 1);
        prod       = scaled[N-1:0];
        prod_ext_o = $signed({{(AW-N){prod[N-1]}}, prod});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clr) begin
            acc_o <= '0;
        end else if (en) begin
            acc_o <= acc_o + prod_ext_o;
        end
    end
endmodule

// File: rtl/ora_seq.sv
module ora_seq
    import ora_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] target,
    input  logic          wrap,
    output logic          clr_o,
    output logic          en_o,
    output logic          done_o
);
    ora_state_e    state, state_nx;
    logic [CW:0]   cnt;
    logic [CW-1:0] tgt_q;
    logic          last;

    assign last = wrap && ((cnt + 1'b1) >= {1'b0, tgt_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            tgt_q <= '0;
        end else if (start) begin
            cnt   <= '0;
            tgt_q <= target;
        end else if (wrap) begin
            cnt   <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (start) state_nx = ST_RUN;
                     else if (last) state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_RUN : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        clr_o  = start;
        en_o   = (state == ST_RUN);
        done_o = (state == ST_DONE);
    end
endmodule

// File: rtl/tone_corr_ora.sv
module tone_corr_ora #(
    parameter int N  = 8,
    parameter int M  = 9,
    parameter int PW = 16,
    parameter int CW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [PW-1:0]          tune_word,
    input  logic [CW-1:0]          period_target,
    input  logic signed [N-1:0]    adc_sample,
    output logic signed [N+M-1:0]  result,
    output logic                   done
);
    localparam int AW = N + M;

    logic                 clr;
    logic                 acc_en;
    logic                 wrap;
    logic signed [N-1:0]  ref_v;
    logic signed [AW-1:0] prod_ext;

    ora_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .target (period_target),
        .wrap   (wrap),
        .clr_o  (clr),
        .en_o   (acc_en),
        .done_o (done)
    );

    ora_ref_tone #(.PW(PW), .N(N)) u_tone (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (acc_en),
        .tw_in  (tune_word),
        .ref_o  (ref_v),
        .wrap_o (wrap)
    );

    ora_mac #(.N(N), .AW(AW)) u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .en         (acc_en),
        .sample     (adc_sample),
        .ref_v      (ref_v),
        .acc_o      (result),
        .prod_ext_o (prod_ext)
    );
endmodule

// File: rtl/ora_chk.sv
module ora_chk #(
    parameter int AW = 17
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 done,
    input logic signed [AW-1:0] result,
    input logic                 acc_en,
    input logic signed [AW-1:0] prod_ext
);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (result == '0) && !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !start) |=> $stable(result));

    // R9
    acc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !start && (result[AW-1] == prod_ext[AW-1])) |=> (result[AW-1] == $past(result[AW-1])));

    // R5
    run_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> !done);
endmodule

bind tone_corr_ora ora_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .result   (result),
    .acc_en   (acc_en),
    .prod_ext (prod_ext)
);

// File: tb/sim_tone_corr_ora.sv
module sim_tone_corr_ora;
    localparam int N  = 8;
    localparam int M  = 9;
    localparam int PW = 16;
    localparam int CW = 8;
    localparam int AW = N + M;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [PW-1:0]         tune_word = '0;
    logic [CW-1:0]         period_target = '0;
    logic signed [N-1:0]   adc_sample = '0;
    logic signed [AW-1:0]  result;
    logic                  done;

    always #10 clk = ~clk;

    tone_corr_ora #(.N(N), .M(M), .PW(PW), .CW(CW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .tune_word     (tune_word),
        .period_target (period_target),
        .adc_sample    (adc_sample),
        .result        (result),
        .done          (done)
    );

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int len_cnt = 0;
    bit finished = 1'b0;
    int    q_res[$];
    int    q_len[$];
    string q_tag[$];

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // R3 reference shape
    function automatic int refv(int ph);
        int u, m;
        u = (ph >> 8) & 127;
        m = (u * (128 - u)) >> 5;
        if (m > 127) m = 127;
        return ((ph & 32768) != 0) ? -m : m;
    endfunction

    function automatic int pat(int pid, int i, int tw);
        case (pid)
            0:       return 100;
            1:       return refv(((i - 1) * tw) % 65536);
            2:       return ((i % 2) != 0) ? 90 : -90;
            default: return ((i * 37) % 256) - 128;
        endcase
    endfunction

    function automatic int sx(logic signed [AW-1:0] v);
        return int'(v);
    endfunction

    // monitor: length counter and scoreboard compare
    always @(posedge clk) begin
        if (start) len_cnt <= 0;
        else       len_cnt <= len_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_res.size() == 0) begin
                chk(1'b0, "R8 done with no pending run", sx(result), 0);
            end else begin
                int e_res, e_len;
                string e_tag;
                e_res = q_res.pop_front();
                e_len = q_len.pop_front();
                e_tag = q_tag.pop_front();
                chk(sx(result) == e_res, {e_tag, " result R4"}, sx(result), e_res);
                chk(len_cnt == e_len, {e_tag, " length R5"}, len_cnt, e_len);
            end
            done_seen++;
        end
    end

    task automatic drive(int tw, int tgt, int pid, int chg_i, int abort_i, string tag);
        int exp_acc, ph, wr, len, lim, seen0;
        exp_acc = 0; ph = 0; wr = 0; len = 0;
        lim = (tgt == 0) ? 1 : tgt;
        if (abort_i == 0) begin
            for (int k = 1; k <= 100000; k++) begin
                int s, r, p;
                s = pat(pid, k, tw);
                r = refv(ph);
                p = (s * r) >>> 7;
                exp_acc += p;
                if (ph + tw >= 65536) wr++;
                ph = (ph + tw) % 65536;
                if (wr >= lim) begin
                    len = k;
                    break;
                end
            end
            q_res.push_back(exp_acc);
            q_len.push_back(len);
            q_tag.push_back(tag);
        end
        seen0 = done_seen;
        tune_word = PW'(tw);
        period_target = CW'(tgt);
        start = 1'b1;
        for (int i = 1; i <= 100000; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chk(result == '0 && !done, {tag, " R2 cleared after start"}, sx(result), 0);
            end
            start = 1'b0;
            adc_sample = N'(pat(pid, i, tw));
            if (i == chg_i) begin
                tune_word = 16'h2345;
                period_target = 8'd7;
            end
            if (abort_i != 0 && i == abort_i) return;
            if (done_seen != seen0) break;
        end
        repeat (4) @(negedge clk);
        chk(sx(result) == exp_acc && !done, {tag, " R6 hold after done"}, sx(result), exp_acc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(result == '0 && !done, "R1 during reset", sx(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(result == '0 && !done, "R1 after reset", sx(result), 0);

        drive(4096, 2, 0, 0, 0, "R5 const two periods");
        drive(4096, 3, 1, 0, 0, "R3 in-phase tone");
        drive(3000, 2, 2, 0, 0, "R5 fractional tuning");
        drive(5000, 0, 3, 0, 0, "R10 zero target");
        drive(4096, 2, 0, 5, 0, "R7 mid-run change");
        drive(4096, 4, 1, 0, 10, "R8 first aborted");
        drive(8192, 1, 2, 0, 0, "R8 restarted run");
        drive(129, 1, 1, 0, 0, "R9 long run");

        repeat (3) @(negedge clk);
        chk(q_res.size() == 0, "R5 all runs completed", q_res.size(), 0);
        wrap_up();
    end
endmodule